// File: doc/BRIEF.md
# Microstep Translator with Decay Selection

This block turns step strobes into per-phase current setpoints for a two-phase bipolar stepper motor. It keeps a position index on a 64-point grid that covers one electrical cycle, with the points 5.625 degrees apart. Each rising edge of the step strobe moves the index by one increment of the selected resolution: full, half, quarter or sixteenth step. The direction input sets which way the index moves. From the index, the block drives phase 1 with a cosine setpoint and phase 2 with a sine setpoint. Each setpoint is an 8-bit magnitude with a separate sign bit.

For every step, the block also labels each phase for the downstream current chopper. A phase whose magnitude grows is flagged for slow decay. A phase whose magnitude shrinks is flagged for mixed decay. After reset, and whenever the home request is raised, the position returns to the 45-degree point, where both phases sit at the same positive level.

Top module: `mstep_translator`

## Requirements
- R1: While reset is held and after it is released, the index sits at 8 (45 degrees). Both magnitudes read 180, both sign bits read 0 and both decay flags read 0 (slow).
- R2: The resolution select picks the index increment per step: 2'b00 full (16), 2'b01 half (8), 2'b10 quarter (4), 2'b11 sixteenth (1).
- R3: With dir_in high the index increases and with dir_in low it decreases. In both cases it wraps modulo 64.
- R4: Only a rising edge of step_in moves the index, and it moves once per edge. A strobe held high for several cycles gives one move. dir_in and res_sel are sampled only on the edge cycle.
- R5: The phase 1 magnitude is round(255·|cos(index·5.625°)|) and the phase 2 magnitude is round(255·|sin(index·5.625°)|). For example, 0° gives 255, 5.625° gives 254, 45° gives 180 and 84.375° gives 25.
- R6: A sign bit is 1 exactly when that phase's setpoint is below zero. A zero magnitude always carries sign 0.
- R7: On each step, a phase's decay flag becomes 0 (slow) if its magnitude rises. It becomes 1 (mixed) if the magnitude falls, or if the magnitude is unchanged but the sign flips. It keeps its value if both the magnitude and the sign are unchanged.
- R8: home_in is synchronous and overrides a step in the same cycle. It puts the index at 8 and clears both decay flags.
- R9: Changing res_sel does not re-align the index. The next step adds the new increment to the index as it stands.
- R10: The outputs take their new values at the same clock edge that first samples step_in high after it was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_in | input | 1 | Step strobe; a rising edge moves one increment |
| dir_in | input | 1 | 1 moves the angle up, 0 moves it down |
| res_sel | input | 2 | Resolution select (see R2) |
| home_in | input | 1 | Synchronous return to the 45-degree position |
| ph1_mag | output | 8 | Phase 1 (cosine) magnitude code |
| ph1_neg | output | 1 | Phase 1 sign, 1 means negative |
| ph1_mixed | output | 1 | Phase 1 decay flag, 1 means mixed, 0 means slow |
| ph2_mag | output | 8 | Phase 2 (sine) magnitude code |
| ph2_neg | output | 1 | Phase 2 sign, 1 means negative |
| ph2_mixed | output | 1 | Phase 2 decay flag, 1 means mixed, 0 means slow |

## Verification
The assertions assume that step_in, dir_in, res_sel and home_in change only away from the active clock edge and are stable at it. The decay checks also rely on each output change coming from a single step or a single home request. The stimulus drives every input on the falling clock edge, so these conditions always hold. It still covers home requests that coincide with a step edge, direction flips while the strobe is held high, and resolution changes between steps.

// File: rtl/mstep_pkg.sv
package mstep_pkg;

    localparam int IDX_W     = 6;
    localparam int MAG_W     = 8;
    localparam int GRID      = 1 << IDX_W;
    localparam int QTR       = GRID / 4;
    localparam int QTR_W     = IDX_W - 2;
    localparam int HOME_IDX  = QTR / 2;
    localparam int NUM_PH    = 2;

    typedef enum logic [1:0] {
        RES_FULL      = 2'b00,
        RES_HALF      = 2'b01,
        RES_QUARTER   = 2'b10,
        RES_SIXTEENTH = 2'b11
    } res_e;

    typedef struct packed {
        logic [MAG_W-1:0] mag;
        logic             neg;
    } phase_t;

    // |cos(j * 5.625 deg)| scaled to 255, j = 0..16
    function automatic logic [MAG_W-1:0] quarter_code(input logic [QTR_W:0] j);
        logic [MAG_W-1:0] c;
        case (j)
            5'd0:  c = 8'd255;
            5'd1:  c = 8'd254;
            5'd2:  c = 8'd250;
            5'd3:  c = 8'd244;
            5'd4:  c = 8'd236;
            5'd5:  c = 8'd225;
            5'd6:  c = 8'd212;
            5'd7:  c = 8'd197;
            5'd8:  c = 8'd180;
            5'd9:  c = 8'd162;
            5'd10: c = 8'd142;
            5'd11: c = 8'd120;
            5'd12: c = 8'd98;
            5'd13: c = 8'd74;
            5'd14: c = 8'd50;
            5'd15: c = 8'd25;
            default: c = 8'd0;
        endcase
        return c;
    endfunction

    function automatic logic [IDX_W-1:0] step_size(input res_e r);
        logic [IDX_W-1:0] s;
        case (r)
            RES_FULL:    s = IDX_W'(QTR);
            RES_HALF:    s = IDX_W'(QTR / 2);
            RES_QUARTER: s = IDX_W'(QTR / 4);
            default:     s = IDX_W'(1);
        endcase
        return s;
    endfunction

endpackage

// File: rtl/mstep_edge.sv
module mstep_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic step_in,
    output logic rise
);
    typedef struct packed {
        logic prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = step_in;
        rise      = step_in & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: two edges can never be seen on back-to-back cycles
    assert_single_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/mstep_index.sv
module mstep_index
    import mstep_pkg::*;
#(
    parameter int HOME = HOME_IDX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             dir,
    input  logic [1:0]       res,
    input  logic             home,
    output logic [IDX_W-1:0] idx_now,
    output logic [IDX_W-1:0] idx_next
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } idx_state_t;

    idx_state_t       st_d, st_q;
    logic [IDX_W-1:0] inc;

    always_comb begin
        st_d = st_q;
        inc  = step_size(res_e'(res));
        if (home)
            st_d.idx = IDX_W'(HOME);
        else if (rise)
            st_d.idx = dir ? st_q.idx + inc : st_q.idx - inc;
        idx_now  = st_q.idx;
        idx_next = st_d.idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{idx: IDX_W'(HOME)};
        else        st_q <= st_d;
    end

    // R4: no edge and no home keeps the position
    assert_idx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!home && !rise) |=> $stable(idx_now));

    // R8: home request lands on the home point
    assert_home_idx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        home |=> (idx_now == IDX_W'(HOME)));

    // R3: a fine step upward moves by exactly one, wrapping
    assert_fine_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !home && dir && res == 2'b11) |=> (idx_now == $past(idx_now) + IDX_W'(1)));

    // R3: a full step downward moves by one quarter cycle
    assert_full_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !home && !dir && res == 2'b00) |=> (idx_now == $past(idx_now) - IDX_W'(QTR)));

endmodule

// File: rtl/mstep_phase_lut.sv
module mstep_phase_lut
    import mstep_pkg::*;
#(
    parameter int OFFSET = 0
) (
    input  logic [IDX_W-1:0] idx,
    output phase_t           ph
);
    logic [IDX_W-1:0] rel;
    logic [1:0]       quad;
    logic [QTR_W-1:0] sub;
    logic [QTR_W:0]   fold;

    always_comb begin
        rel  = idx - IDX_W'(OFFSET);
        quad = rel[IDX_W-1:IDX_W-2];
        sub  = rel[QTR_W-1:0];
        fold = quad[0] ? (QTR_W+1)'(QTR) - {1'b0, sub} : {1'b0, sub};
        ph.mag = quarter_code(fold);
        ph.neg = (quad == 2'd2) || (quad == 2'd1 && sub != '0);
    end

endmodule

// File: rtl/mstep_decay.sv
module mstep_decay
    import mstep_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   upd,
    input  logic   home,
    input  phase_t ph_cur,
    input  phase_t ph_nxt,
    output logic   mixed
);
    typedef struct packed {
        logic mixed;
    } decay_state_t;

    decay_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (home) begin
            st_d.mixed = 1'b0;
        end else if (upd) begin
            if (ph_nxt.mag > ph_cur.mag)
                st_d.mixed = 1'b0;
            else if (ph_nxt.mag < ph_cur.mag)
                st_d.mixed = 1'b1;
            else if (ph_nxt.neg != ph_cur.neg)
                st_d.mixed = 1'b1;
        end
        mixed = st_q.mixed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: home leaves the phase in slow decay
    assert_home_slow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        home |=> !mixed);

endmodule

// File: rtl/mstep_translator.sv
module mstep_translator
    import mstep_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_in,
    input  logic             dir_in,
    input  logic [1:0]       res_sel,
    input  logic             home_in,
    output logic [MAG_W-1:0] ph1_mag,
    output logic             ph1_neg,
    output logic             ph1_mixed,
    output logic [MAG_W-1:0] ph2_mag,
    output logic             ph2_neg,
    output logic             ph2_mixed
);
    logic             rise;
    logic [IDX_W-1:0] idx_now;
    logic [IDX_W-1:0] idx_next;
    phase_t           ph_cur [NUM_PH];
    phase_t           ph_nxt [NUM_PH];
    logic             mixed  [NUM_PH];

    mstep_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_in (step_in),
        .rise    (rise)
    );

    mstep_index #(.HOME(HOME_IDX)) u_index (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .dir      (dir_in),
        .res      (res_sel),
        .home     (home_in),
        .idx_now  (idx_now),
        .idx_next (idx_next)
    );

    for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
        mstep_phase_lut #(.OFFSET(p * QTR)) u_lut_cur (
            .idx (idx_now),
            .ph  (ph_cur[p])
        );
        mstep_phase_lut #(.OFFSET(p * QTR)) u_lut_nxt (
            .idx (idx_next),
            .ph  (ph_nxt[p])
        );
        mstep_decay u_decay (
            .clk    (clk),
            .rst_n  (rst_n),
            .upd    (rise),
            .home   (home_in),
            .ph_cur (ph_cur[p]),
            .ph_nxt (ph_nxt[p]),
            .mixed  (mixed[p])
        );
    end

    assign ph1_mag   = ph_cur[0].mag;
    assign ph1_neg   = ph_cur[0].neg;
    assign ph1_mixed = mixed[0];
    assign ph2_mag   = ph_cur[1].mag;
    assign ph2_neg   = ph_cur[1].neg;
    assign ph2_mixed = mixed[1];

    // R7: a growing magnitude is always in slow decay
    assert_rise_slow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ph1_mag > $past(ph1_mag)) |-> !ph1_mixed);

    // R7: a shrinking magnitude not caused by home is in mixed decay
    assert_fall_mixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(home_in) && ph2_mag < $past(ph2_mag)) |-> ph2_mixed);

    // R7: nothing moved, flag holds
    assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(home_in) && $stable(ph1_mag) && $stable(ph1_neg)) |-> $stable(ph1_mixed));

    // R6: a zero setpoint is never negative
    assert_zero_pos_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ph2_mag == '0) |-> !ph2_neg);

endmodule

// File: tb/mstep_translator_test.sv
module mstep_translator_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_in = 1'b0;
    logic       dir_in = 1'b1;
    logic [1:0] res_sel = 2'b11;
    logic       home_in = 1'b0;
    logic [7:0] ph1_mag, ph2_mag;
    logic       ph1_neg, ph1_mixed, ph2_neg, ph2_mixed;

    int    checks = 0;
    int    errors = 0;
    string scen = "R1";
    bit    live = 1'b0;
    bit    done = 1'b0;

    always #10 clk = ~clk;

    mstep_translator uut (
        .clk(clk), .rst_n(rst_n), .step_in(step_in), .dir_in(dir_in),
        .res_sel(res_sel), .home_in(home_in),
        .ph1_mag(ph1_mag), .ph1_neg(ph1_neg), .ph1_mixed(ph1_mixed),
        .ph2_mag(ph2_mag), .ph2_neg(ph2_neg), .ph2_mixed(ph2_mixed)
    );

    // ---------------- reference model ----------------
    function automatic real wave(input int i, input int ph);
        real a;
        a = i * 5.625 * 3.14159265358979 / 180.0;
        return (ph == 0) ? $cos(a) : $sin(a);
    endfunction

    function automatic int exp_code(input int i, input int ph);
        real v;
        v = wave(i, ph);
        if (v < 0.0) v = -v;
        return $rtoi(v * 255.0 + 0.5);
    endfunction

    function automatic int exp_neg(input int i, input int ph);
        return (wave(i, ph) < -1.0e-9) ? 1 : 0;
    endfunction

    int m_idx = 8;
    bit m_prev = 1'b0;
    bit m_mix [2] = '{1'b0, 1'b0};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_idx  <= 8;
            m_prev <= 1'b0;
            m_mix  <= '{1'b0, 1'b0};
        end else begin
            m_prev <= step_in;
            if (home_in) begin
                m_idx <= 8;
                m_mix <= '{1'b0, 1'b0};
            end else if (step_in && !m_prev) begin
                int inc, ni;
                case (res_sel)
                    2'b00: inc = 16;
                    2'b01: inc = 8;
                    2'b10: inc = 4;
                    default: inc = 1;
                endcase
                ni = (m_idx + (dir_in ? inc : -inc) + 64) % 64;
                for (int p = 0; p < 2; p++) begin
                    int om, nm;
                    om = exp_code(m_idx, p);
                    nm = exp_code(ni, p);
                    if (nm > om) m_mix[p] <= 1'b0;
                    else if (nm < om) m_mix[p] <= 1'b1;
                    else if (exp_neg(ni, p) != exp_neg(m_idx, p)) m_mix[p] <= 1'b1;
                end
                m_idx <= ni;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", scen, tag, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (live && !done) begin
            chk("R5 ph1_mag", ph1_mag, exp_code(m_idx, 0));
            chk("R5 ph2_mag", ph2_mag, exp_code(m_idx, 1));
            chk("R6 ph1_neg", ph1_neg, exp_neg(m_idx, 0));
            chk("R6 ph2_neg", ph2_neg, exp_neg(m_idx, 1));
            chk("R7 ph1_mixed", ph1_mixed, m_mix[0]);
            chk("R7 ph2_mixed", ph2_mixed, m_mix[1]);
        end
    end

    // ---------------- stimulus ----------------
    task automatic pulse(input bit d, input logic [1:0] r, input int hold);
        @(negedge clk);
        dir_in = d; res_sel = r; step_in = 1'b1;
        repeat (hold) @(negedge clk);
        step_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk("R1 reset mag1", ph1_mag, 180);
        chk("R1 reset mag2", ph2_mag, 180);
        chk("R1 reset flags", {ph1_neg, ph2_neg, ph1_mixed, ph2_mixed}, 0);
        rst_n = 1'b1;
        live = 1'b1;
        @(negedge clk);

        // R10: first sampled high edge updates outputs at once
        scen = "R10";
        @(negedge clk);
        dir_in = 1'b1; res_sel = 2'b11; step_in = 1'b1;
        @(negedge clk);
        chk("R10 ph1_mag after edge", ph1_mag, 180 - 18);
        step_in = 1'b0;
        @(negedge clk);

        // R2 / R3: every resolution forward across the wrap
        scen = "R2";
        for (int i = 0; i < 70; i++) pulse(1'b1, 2'b11, 1);
        for (int i = 0; i < 10; i++) pulse(1'b1, 2'b10, 1);
        for (int i = 0; i < 9;  i++) pulse(1'b1, 2'b01, 1);
        for (int i = 0; i < 6;  i++) pulse(1'b1, 2'b00, 1);

        scen = "R3";
        for (int i = 0; i < 70; i++) pulse(1'b0, 2'b11, 1);
        for (int i = 0; i < 10; i++) pulse(1'b0, 2'b10, 1);
        for (int i = 0; i < 9;  i++) pulse(1'b0, 2'b01, 1);
        for (int i = 0; i < 6;  i++) pulse(1'b0, 2'b00, 1);

        // R4: long strobe, direction and mode wiggle while held
        scen = "R4";
        @(negedge clk);
        dir_in = 1'b1; res_sel = 2'b10; step_in = 1'b1;
        @(negedge clk); dir_in = 1'b0;
        @(negedge clk); res_sel = 2'b00;
        repeat (4) @(negedge clk);
        step_in = 1'b0;
        @(negedge clk);
        pulse(1'b1, 2'b11, 6);

        // R9: switch to coarse steps from an unaligned index
        scen = "R9";
        pulse(1'b1, 2'b11, 1);
        pulse(1'b1, 2'b11, 1);
        for (int i = 0; i < 5; i++) pulse(1'b1, 2'b00, 1);
        pulse(1'b0, 2'b01, 1);
        pulse(1'b1, 2'b10, 2);

        // R8: plain home, then home coinciding with a step edge
        scen = "R8";
        @(negedge clk); home_in = 1'b1;
        @(negedge clk); home_in = 1'b0;
        chk("R8 home mag1", ph1_mag, 180);
        for (int i = 0; i < 3; i++) pulse(1'b0, 2'b11, 1);
        @(negedge clk);
        home_in = 1'b1; step_in = 1'b1; dir_in = 1'b1; res_sel = 2'b00;
        @(negedge clk);
        home_in = 1'b0;
        chk("R8 home over step mixed", {ph1_mixed, ph2_mixed}, 0);
        @(negedge clk); step_in = 1'b0;
        @(negedge clk);

        // R7: scattered traffic
        scen = "R7";
        for (int i = 0; i < 400; i++) begin
            logic [3:0] rv;
            rv = 4'($urandom);
            if (rv == 4'd0) begin
                @(negedge clk); home_in = 1'b1;
                @(negedge clk); home_in = 1'b0;
            end else begin
                pulse(rv[3], rv[1:0], 1 + int'(rv[2]));
            end
        end
        repeat (3) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R10 actual %0d expected %0d", 1, 0);
        finish_run();
    end

endmodule